// File: doc/BRIEF.md
# Multi-Channel Time Compare and Cycle Reset Unit

This block watches a free-running time counter and compares it, every clock, against a bank of programmable compare values, one per channel. When an enabled channel's value equals the counter, the block raises a sticky status bit for that channel and drives a one-cycle event pulse. Software clears status bits by writing ones to them.

Channel 0 has a second role. When the reset option is on, a channel-0 match asserts a counter-reset output, so the external counter returns to zero on the next edge. The timer then becomes a cyclic counter whose period is set by the channel-0 value. For a period of T time units and a counter step of INC, channel 0 holds T - INC.

Compare values can optionally be double-buffered. In shadow mode, software writes land in a shadow copy, and all active compare values take the shadow contents together when the channel-0 reset fires. A new cycle length therefore never takes effect in the middle of a cycle. The counter itself and any pulse shaping sit outside the block.

Top module: `cmp_cycle_unit`

## Requirements
- R1: After reset the configuration word, the status word, every compare value, every event output and the counter-reset output are all zero.
- R2: For channel n whose enable (configuration bit n+1) is set, the block detects a match when the full CNT_W-bit compare value equals `cnt_i`, including the upper half.
- R3: A match seen at a clock edge sets status bit n and pulses `evt_o[n]` for exactly one cycle after that same edge. The status bit stays set after the pulse ends.
- R4: Writing the status word (address 1) clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R5: When configuration bit 0 and the channel-0 enable are both set, `cnt_rst_o` is high combinationally during the cycle in which `cnt_i` equals the channel-0 value. Programming T - INC therefore gives a counter cycle of exactly T.
- R6: Register map, word addressed: address 0 is the configuration word, address 1 is the status word, address 2+2n is the low 32 bits of channel n and address 3+2n is its upper bits. A read of a compare address returns the active compare value. Other addresses read as zero.
- R7: With configuration bit NUM_CH+1 (bit 17 for 16 channels) set, compare writes go only to the shadow copy and the active values stay unchanged. All channels load their shadow copy at the edge where `cnt_rst_o` is high. With the bit clear, a compare write takes effect at its own edge.
- R8: A channel whose enable bit is clear never sets its status bit and never pulses its event output, even when its value equals the counter.
- R9: When a match and a write-1-to-clear reach the same status bit at the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Current time counter value |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write word address |
| wr_data_i | input | REG_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read word address |
| rd_data_o | output | REG_W | Register read data (combinational) |
| evt_o | output | NUM_CH | Per-channel one-cycle match event |
| cnt_rst_o | output | 1 | Counter reset request from a channel-0 match |

## Verification
The bound checker enforces several rules on every cycle:
- A disabled channel never produces an event.
- Every event is mirrored by a set status bit.
- Status bits only fall after a status write.
- Each counter-reset request is followed by a channel-0 event.
- In shadow mode, active compare values stay frozen except at a counter reset.

Some behaviour only the directed scenarios can show. These cover:
- the exact match on both counter halves;
- register readback;
- the priority of set over clear;
- the wrap sequence of a cyclic counter with a period of T;
- a shadow-written cycle length that takes effect only after the next wrap.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
   // word addresses of the register file
   localparam int unsigned CFG_ADDR = 0;
   localparam int unsigned STS_ADDR = 1;
   localparam int unsigned CMP_BASE = 2;
   // configuration word layout
   localparam int unsigned RST_BIT  = 0;
   localparam int unsigned EN_LSB   = 1;

   function automatic int unsigned shadow_bit(input int unsigned nch);
      return nch + EN_LSB;
   endfunction
endpackage

// File: rtl/cmpu_channel.sv
module cmpu_channel #(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned REG_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             en_i,
   input  logic             shadow_i,
   input  logic             wr_lo_i,
   input  logic             wr_hi_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic             reload_i,
   output logic [CNT_W-1:0] value_o,
   output logic             match_o
);
   localparam int unsigned HI_W = CNT_W - REG_W;

   logic [CNT_W-1:0] act_q, shd_q, shd_d;

   always_comb begin
      shd_d = shd_q;
      if (wr_lo_i) shd_d[REG_W-1:0]     = wr_data_i;
      if (wr_hi_i) shd_d[CNT_W-1:REG_W] = wr_data_i[HI_W-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q <= '0;
         shd_q <= '0;
      end else begin
         shd_q <= shd_d;
         if (!shadow_i || reload_i) act_q <= shd_d;
      end
   end

   assign value_o = act_q;
   assign match_o = en_i && (act_q == cnt_i);
endmodule

// File: rtl/cmpu_status.sv
module cmpu_status #(
   parameter int unsigned NUM_CH = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_CH-1:0] set_i,
   input  logic              clr_we_i,
   input  logic [NUM_CH-1:0] clr_mask_i,
   output logic [NUM_CH-1:0] sts_o,
   output logic [NUM_CH-1:0] evt_o
);
   logic [NUM_CH-1:0] clr;

   assign clr = clr_we_i ? clr_mask_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sts_o <= '0;
         evt_o <= '0;
      end else begin
         sts_o <= (sts_o & ~clr) | set_i;
         evt_o <= set_i;
      end
   end
endmodule

// File: rtl/cmp_cycle_unit.sv
module cmp_cycle_unit
   import cmpu_pkg::*;
#(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned REG_W  = 32,
   localparam int unsigned ADDR_W = $clog2(CMP_BASE + 2 * NUM_CH)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [REG_W-1:0]  wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [REG_W-1:0]  rd_data_o,
   output logic [NUM_CH-1:0] evt_o,
   output logic              cnt_rst_o
);
   localparam int unsigned CFG_W  = NUM_CH + 2;
   localparam int unsigned SHD    = shadow_bit(NUM_CH);
   localparam int unsigned HI_W   = CNT_W - REG_W;

   if (NUM_CH < 1 || CFG_W > REG_W) begin : g_bad_nch
      $error("NUM_CH must be 1..REG_W-2");
   end
   if (CNT_W <= REG_W || CNT_W > 2 * REG_W) begin : g_bad_cntw
      $error("CNT_W must lie in (REG_W, 2*REG_W]");
   end

   logic [CFG_W-1:0]        cfg_q;
   logic [NUM_CH-1:0]       match, sts_q;
   logic [CNT_W-1:0]        act_v [NUM_CH];
   logic [NUM_CH*CNT_W-1:0] act_flat;
   logic                    shadow_on, reload;

   assign shadow_on = cfg_q[SHD];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cfg_q <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(CFG_ADDR))
         cfg_q <= wr_data_i[CFG_W-1:0];
   end

   assign cnt_rst_o = cfg_q[RST_BIT] && match[0];
   assign reload    = cnt_rst_o && shadow_on;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic wr_lo, wr_hi;
      assign wr_lo = wr_en_i && wr_addr_i == ADDR_W'(CMP_BASE + 2 * n);
      assign wr_hi = wr_en_i && wr_addr_i == ADDR_W'(CMP_BASE + 2 * n + 1);

      cmpu_channel #(.CNT_W(CNT_W), .REG_W(REG_W)) u_ch (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .cnt_i     (cnt_i),
         .en_i      (cfg_q[EN_LSB + n]),
         .shadow_i  (shadow_on),
         .wr_lo_i   (wr_lo),
         .wr_hi_i   (wr_hi),
         .wr_data_i (wr_data_i),
         .reload_i  (reload),
         .value_o   (act_v[n]),
         .match_o   (match[n])
      );
      assign act_flat[n*CNT_W +: CNT_W] = act_v[n];
   end

   cmpu_status #(.NUM_CH(NUM_CH)) u_sts (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (match),
      .clr_we_i   (wr_en_i && wr_addr_i == ADDR_W'(STS_ADDR)),
      .clr_mask_i (wr_data_i[NUM_CH-1:0]),
      .sts_o      (sts_q),
      .evt_o      (evt_o)
   );

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == ADDR_W'(CFG_ADDR)) begin
         rd_data_o[CFG_W-1:0] = cfg_q;
      end else if (rd_addr_i == ADDR_W'(STS_ADDR)) begin
         rd_data_o[NUM_CH-1:0] = sts_q;
      end else begin
         for (int n = 0; n < NUM_CH; n++) begin
            if (rd_addr_i == ADDR_W'(CMP_BASE + 2 * n))
               rd_data_o = act_v[n][REG_W-1:0];
            if (rd_addr_i == ADDR_W'(CMP_BASE + 2 * n + 1))
               rd_data_o[HI_W-1:0] = act_v[n][CNT_W-1:REG_W];
         end
      end
   end
endmodule

// File: rtl/cmp_cycle_unit_chk.sv
module cmp_cycle_unit_chk #(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned CFG_W  = NUM_CH + 2
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic                    wr_en_i,
   input logic [ADDR_W-1:0]       wr_addr_i,
   input logic [CFG_W-1:0]        cfg_q,
   input logic [NUM_CH-1:0]       sts_q,
   input logic [NUM_CH-1:0]       evt_o,
   input logic                    cnt_rst_o,
   input logic [NUM_CH*CNT_W-1:0] act_flat
);
   AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((evt_o & ~$past(cfg_q[NUM_CH:1])) == '0)); // R8

   AST_EVT_IN_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((evt_o & ~sts_q) == '0)); // R3

   AST_STICKY_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_addr_i == ADDR_W'(1)) |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R4

   AST_RST_GIVES_EVT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_rst_o |=> evt_o[0]); // R5

   AST_SHADOW_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[NUM_CH+1] && !cnt_rst_o) |=> $stable(act_flat)); // R7
endmodule

bind cmp_cycle_unit cmp_cycle_unit_chk #(
   .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .wr_en_i   (wr_en_i),
   .wr_addr_i (wr_addr_i),
   .cfg_q     (cfg_q),
   .sts_q     (sts_q),
   .evt_o     (evt_o),
   .cnt_rst_o (cnt_rst_o),
   .act_flat  (act_flat)
);

// File: tb/cmp_cycle_unit_test.sv
`timescale 1ns/1ps
module cmp_cycle_unit_test;
   localparam int NUM_CH = 16;
   localparam int CNT_W  = 64;
   localparam int REG_W  = 32;
   localparam int ADDR_W = $clog2(2 + 2 * NUM_CH);
   localparam int INC    = 4;

   logic              clk = 0, rst_n = 0;
   logic [CNT_W-1:0]  cnt = '0;
   logic              wr_en = 0;
   logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
   logic [REG_W-1:0]  wr_data = '0, rd_data;
   logic [NUM_CH-1:0] evt;
   logic              cnt_rst;
   logic              auto = 0;
   logic              done = 0;
   int                checks = 0, errors = 0;

   always #10 clk = ~clk;

   always @(posedge clk) if (auto) cnt <= cnt_rst ? '0 : cnt + INC;

   cmp_cycle_unit #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .REG_W(REG_W)) uut (
      .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
      .rd_data_o(rd_data), .evt_o(evt), .cnt_rst_o(cnt_rst)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1; wr_addr = ADDR_W'(addr); wr_data = data;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input int addr, output logic [31:0] data);
      rd_addr = ADDR_W'(addr);
      #1 data = rd_data;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(0, d); check("R1 cfg", d, 0);
      rd(1, d); check("R1 status", d, 0);
      rd(2, d); check("R1 cmp0 lo", d, 0);
      check("R1 evt", evt, 0);
      check("R1 cnt_rst", cnt_rst, 0);
   endtask

   task automatic t_match;
      logic [31:0] d;
      wr(2 + 2*3, 40);
      rd(2 + 2*3, d); check("R6 cmp3 lo readback", d, 40);
      wr(2 + 2*5, 8); wr(3 + 2*5, 1);
      rd(3 + 2*5, d); check("R6 cmp5 hi readback", d, 1);
      wr(0, 32'h50);                      // enable ch3 (bit 4) and ch5 (bit 6)
      rd(0, d); check("R6 cfg readback", d, 32'h50);
      cnt = 40;
      @(negedge clk);
      check("R3 evt3 pulse", evt[3], 1);
      rd(1, d); check("R3 status3 set", d[3], 1);
      cnt = 8;
      @(negedge clk);
      check("R3 evt3 one cycle", evt[3], 0);
      check("R2 upper half mismatch", evt[5], 0);
      rd(1, d); check("R3 status3 sticky", d[3], 1);
      cnt = 64'h1_0000_0008;
      @(negedge clk);
      check("R2 full 64-bit match", evt[5], 1);
      cnt = 64'h44;
   endtask

   task automatic t_disabled;
      logic [31:0] d;
      wr(2 + 2*7, 100);
      cnt = 100;
      @(negedge clk); @(negedge clk);
      check("R8 disabled evt7", evt[7], 0);
      rd(1, d); check("R8 disabled status7", d[7], 0);
      cnt = 44;
   endtask

   task automatic t_w1c;
      logic [31:0] d;
      wr(1, 32'h8);                       // clear bit 3 only
      rd(1, d);
      check("R4 bit3 cleared", d[3], 0);
      check("R4 bit5 kept", d[5], 1);
   endtask

   task automatic t_set_wins;
      logic [31:0] d;
      cnt = 40;                           // ch3 matches every cycle
      @(negedge clk);
      wr(1, 32'h8);
      rd(1, d); check("R9 set beats clear", d[3], 1);
      cnt = 44;
      wr(1, 32'hffff);
      rd(1, d); check("R4 clear all", d, 0);
   endtask

   task automatic t_cycle;
      wr(0, 0);
      wr(2, 36);                          // T=40, INC=4
      wr(3, 0);
      wr(0, 32'h3);                       // reset enable + ch0 enable
      cnt = 0; auto = 1;
      for (int j = 1; j <= 25; j++) begin
         @(negedge clk);
         check("R5 cyclic count", cnt, 64'((j % 10) * INC));
         check("R5 cnt_rst at T-INC", cnt_rst, ((j % 10) == 9));
         check("R3 evt0 after wrap", evt[0], ((j % 10) == 0));
      end
   endtask

   task automatic t_shadow;
      logic [31:0] d;
      wr(0, 32'h3 | (32'h1 << 17));
      while (cnt_rst !== 1'b1) @(negedge clk);
      wr(2, 76);                          // new T=80 into shadow
      rd(2, d); check("R7 active unchanged", d, 36);
      while (cnt_rst !== 1'b1) @(negedge clk);
      check("R7 old period still used", cnt, 36);
      @(negedge clk);
      rd(2, d); check("R7 loaded at wrap", d, 76);
      check("R7 count restarted", cnt, 0);
      for (int j = 0; j < 10; j++) @(negedge clk);
      check("R7 new period in force", cnt, 40);
      check("R7 no early reset", cnt_rst, 0);
      auto = 0;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_match();
      t_disabled();
      t_w1c();
      t_set_wins();
      t_cycle();
      t_shadow();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule